// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a hardware-managed translation buffer after a miss. It accepts a 20-bit virtual page number and a master table base, then resolves the translation with two dependent memory reads. The upper index bits select an entry in the master table, and that entry gives the base of a secondary table. The lower index bits select the leaf entry in that secondary table. The walker either hands the leaf entry back for installation or ends with a fault that names the level where the walk stopped.

The tables sit in memory in a fixed layout that the walker reads directly through a request/grant/response port. Every table entry is 32 bits wide. Bit 0 is the valid flag. For a master entry, bits 31:12 hold the page-aligned base of the secondary table. A leaf entry is returned unchanged. The address of an entry is the table base plus the index times 4.

The states are IDLE, READ_L1, WAIT_L1, READ_L2, WAIT_L2, DONE and FAULT. The transitions are:
- IDLE goes to READ_L1 on an accepted miss.
- READ_L1 goes to WAIT_L1 on a grant.
- WAIT_L1 goes to READ_L2 on a valid master response, or to FAULT on an invalid one.
- READ_L2 goes to WAIT_L2 on a grant.
- WAIT_L2 goes to DONE on a valid leaf, or to FAULT on an invalid leaf.
- DONE and FAULT each return to IDLE after one cycle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done` and `fault` are all low.
- R2: The first read goes to `root_base + miss_vpn[19:10]*4`, using the root base captured when the miss was accepted.
- R3: The second read goes to `{master_entry[31:12], 12'h000} + miss_vpn[9:0]*4`. It is issued only after the master response has arrived.
- R4: While `mem_req` is high without `mem_gnt`, the request and its address stay unchanged. Each level makes exactly one read.
- R5: A master entry with bit 0 clear ends the walk with `fault` and `fault_level` = 0, and no second read is made.
- R6: A leaf entry with bit 0 clear ends the walk with `fault` and `fault_level` = 1. `fault_vpn` equals the missed page number.
- R7: On a valid leaf, `done` pulses for one cycle, and `done_pte` equals the leaf word exactly.
- R8: `busy` rises in the cycle after a miss is accepted and stays high through the cycle of the `done` or `fault` pulse. It is low in the cycle after that pulse.
- R9: `miss_valid` is ignored whenever the walker is not in IDLE, including the cycle of the `done` pulse.
- R10: `done` and `fault` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request, taken only in IDLE |
| miss_vpn | input | 20 | Virtual page number that missed |
| root_base | input | 32 | Byte address of the master table |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the requested entry |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: the walk succeeded |
| done_pte | output | 32 | Leaf entry, valid with `done` |
| fault | output | 1 | One-cycle pulse: the walk hit an invalid entry |
| fault_vpn | output | 20 | Page number of the failed walk |
| fault_level | output | 1 | 0 = master entry invalid, 1 = leaf entry invalid |

## Verification
Two events can fall in the same cycle: the completion pulse of one walk and the arrival of a new miss. The bench holds `miss_valid` high with a different page number and root for the whole walk, including the cycle in which `done` pulses. It then drops the request and watches for several cycles. The design passes if `done_pte` carries the first walk's leaf, `busy` falls, and no further memory request appears.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    localparam int VA_W    = 32;
    localparam int L1_W    = 10;
    localparam int L2_W    = 10;
    localparam int OFF_W   = 12;
    localparam int ENTRY_B = 4;

    typedef enum logic [2:0] {
        IDLE    = 3'd0,
        READ_L1 = 3'd1,
        WAIT_L1 = 3'd2,
        READ_L2 = 3'd3,
        WAIT_L2 = 3'd4,
        DONE    = 3'd5,
        FAULT   = 3'd6
    } walk_state_t;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int PA_W    = 32,
    parameter int IDX_W   = 10,
    parameter int ENTRY_B = 4,
    parameter int OFF_W   = 12,
    parameter bit ALIGNED = 1'b0
) (
    input  logic [PA_W-1:0]  base_in,
    input  logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int SHIFT = $clog2(ENTRY_B);

    logic [PA_W-1:0] base_eff;
    logic [PA_W-1:0] offs;

    generate
        if (ALIGNED) begin : g_aligned
            assign base_eff = {base_in[PA_W-1:OFF_W], {OFF_W{1'b0}}};
        end else begin : g_raw
            assign base_eff = base_in;
        end
    endgenerate

    assign offs       = {{(PA_W-IDX_W){1'b0}}, idx} << SHIFT;
    assign entry_addr = base_eff + offs;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int PA_W  = VA_W,
    parameter int L1W   = L1_W,
    parameter int L2W   = L2_W,
    parameter int OFFW  = OFF_W,
    parameter int EB    = ENTRY_B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 miss_valid,
    input  logic [L1W+L2W-1:0]   miss_vpn,
    input  logic [PA_W-1:0]      root_base,
    output logic                 mem_req,
    output logic [PA_W-1:0]      mem_addr,
    input  logic                 mem_gnt,
    input  logic                 mem_rvalid,
    input  logic [PA_W-1:0]      mem_rdata,
    output logic                 busy,
    output logic                 done,
    output logic [PA_W-1:0]      done_pte,
    output logic                 fault,
    output logic [L1W+L2W-1:0]   fault_vpn,
    output logic                 fault_level
);
    localparam int VPN_W = L1W + L2W;

    walk_state_t state_q, state_d;

    logic [VPN_W-1:0] vpn_q;
    logic [PA_W-1:0]  root_q;
    logic [PA_W-1:0]  sec_base_q;
    logic [PA_W-1:0]  leaf_q;
    logic             lvl_q;
    logic [PA_W-1:0]  l1_addr;
    logic [PA_W-1:0]  l2_addr;
    logic             rd_ok;

    assign rd_ok = mem_rdata[0];

    pt_addr_gen #(
        .PA_W(PA_W), .IDX_W(L1W), .ENTRY_B(EB), .OFF_W(OFFW), .ALIGNED(1'b0)
    ) u_l1_addr (
        .base_in(root_q), .idx(vpn_q[VPN_W-1:L2W]), .entry_addr(l1_addr)
    );

    pt_addr_gen #(
        .PA_W(PA_W), .IDX_W(L2W), .ENTRY_B(EB), .OFF_W(OFFW), .ALIGNED(1'b1)
    ) u_l2_addr (
        .base_in(sec_base_q), .idx(vpn_q[L2W-1:0]), .entry_addr(l2_addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IDLE;
        else        state_q <= state_d;
    end

    // walk context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q      <= '0;
            root_q     <= '0;
            sec_base_q <= '0;
            leaf_q     <= '0;
            lvl_q      <= 1'b0;
        end else begin
            unique case (state_q)
                IDLE: if (miss_valid) begin
                    vpn_q  <= miss_vpn;
                    root_q <= root_base;
                end
                WAIT_L1: if (mem_rvalid) begin
                    sec_base_q <= mem_rdata;
                    lvl_q      <= 1'b0;
                end
                WAIT_L2: if (mem_rvalid) begin
                    leaf_q <= mem_rdata;
                    lvl_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE:    if (miss_valid) state_d = READ_L1;
            READ_L1: if (mem_gnt)    state_d = WAIT_L1;
            WAIT_L1: if (mem_rvalid) state_d = rd_ok ? READ_L2 : FAULT;
            READ_L2: if (mem_gnt)    state_d = WAIT_L2;
            WAIT_L2: if (mem_rvalid) state_d = rd_ok ? DONE : FAULT;
            DONE:    state_d = IDLE;
            FAULT:   state_d = IDLE;
            default: state_d = IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req     = 1'b0;
        mem_addr    = '0;
        busy        = 1'b1;
        done        = 1'b0;
        fault       = 1'b0;
        done_pte    = leaf_q;
        fault_vpn   = vpn_q;
        fault_level = lvl_q;
        unique case (state_q)
            IDLE:    busy = 1'b0;
            READ_L1: begin mem_req = 1'b1; mem_addr = l1_addr; end
            READ_L2: begin mem_req = 1'b1; mem_addr = l2_addr; end
            DONE:    done  = 1'b1;
            FAULT:   fault = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            miss_valid,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_gnt,
    input logic            busy,
    input logic            done,
    input logic            fault
);
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    p_done_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fault_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> busy);

    p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !busy);

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && miss_valid) |=> busy);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .busy(busy), .done(done), .fault(fault)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [19:0] miss_vpn = '0;
    logic [31:0] root_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, fault, fault_level;
    logic [31:0] done_pte;
    logic [19:0] fault_vpn;

    int total = 0;
    int bad = 0;
    int reads = 0;
    int gnt_wait = 0;
    int rsp_wait = 0;
    logic [31:0] addr_log [0:7];
    logic [31:0] mem [logic [31:0]];

    always #2 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .root_base(root_base), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .done_pte(done_pte), .fault(fault),
        .fault_vpn(fault_vpn), .fault_level(fault_level)
    );

    function automatic logic [31:0] lookup(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory responder
    initial begin
        logic [31:0] a;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                repeat (gnt_wait) @(negedge clk);
                mem_gnt = 1'b1;
                a = mem_addr;
                if (reads < 8) addr_log[reads] = a;
                reads++;
                @(negedge clk);
                mem_gnt = 1'b0;
                repeat (rsp_wait) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = lookup(a);
                @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [19:0] v, input logic [31:0] rb);
        @(negedge clk);
        miss_vpn = v; root_base = rb; miss_valid = 1'b1; reads = 0;
        @(negedge clk);
        miss_valid = 1'b0;
        check("R8 busy after accept", {31'b0, busy}, 32'd1);
    endtask

    task automatic wait_end(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (done || fault) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        if (!ok) check("R7 walk ended", 32'd0, 32'd1);
    endtask

    task automatic test_reset();
        check("R1 busy", {31'b0, busy}, 0);
        check("R1 mem_req", {31'b0, mem_req}, 0);
        check("R1 done", {31'b0, done}, 0);
        check("R1 fault", {31'b0, fault}, 0);
    endtask

    task automatic test_good(input logic [19:0] v, input logic [31:0] rb,
                             input logic [31:0] sb, input logic [31:0] leaf,
                             input int gw, input int rw);
        bit ok;
        logic [31:0] a1, a2;
        gnt_wait = gw; rsp_wait = rw;
        a1 = rb + {20'b0, v[19:10], 2'b00};
        a2 = {sb[31:12], 12'h000} + {20'b0, v[9:0], 2'b00};
        mem[a1] = {sb[31:12], 12'h001};
        mem[a2] = leaf;
        launch(v, rb);
        wait_end(ok);
        if (ok) begin
            check("R7 done", {31'b0, done}, 1);
            check("R10 no fault with done", {31'b0, fault}, 0);
            check("R7 pte", done_pte, leaf);
            check("R8 busy at pulse", {31'b0, busy}, 1);
            check("R2 master addr", addr_log[0], a1);
            check("R3 leaf addr", addr_log[1], a2);
            @(negedge clk);
            check("R10 done one cycle", {31'b0, done}, 0);
            check("R8 busy low after", {31'b0, busy}, 0);
            check("R4 two reads", reads, 2);
        end
    endtask

    task automatic test_bad_master(input logic [19:0] v, input logic [31:0] rb);
        bit ok;
        gnt_wait = 1; rsp_wait = 1;
        mem[rb + {20'b0, v[19:10], 2'b00}] = 32'hDEAD_B000;
        launch(v, rb);
        wait_end(ok);
        if (ok) begin
            check("R5 fault", {31'b0, fault}, 1);
            check("R5 level", {31'b0, fault_level}, 0);
            check("R5 vpn", {12'b0, fault_vpn}, {12'b0, v});
            check("R10 no done with fault", {31'b0, done}, 0);
            repeat (4) @(negedge clk);
            check("R5 single read", reads, 1);
            check("R8 busy low", {31'b0, busy}, 0);
        end
    endtask

    task automatic test_bad_leaf(input logic [19:0] v, input logic [31:0] rb,
                                 input logic [31:0] sb);
        bit ok;
        gnt_wait = 2; rsp_wait = 0;
        mem[rb + {20'b0, v[19:10], 2'b00}] = {sb[31:12], 12'h001};
        mem[{sb[31:12], 12'h000} + {20'b0, v[9:0], 2'b00}] = 32'h5555_5FFE;
        launch(v, rb);
        wait_end(ok);
        if (ok) begin
            check("R6 fault", {31'b0, fault}, 1);
            check("R6 level", {31'b0, fault_level}, 1);
            check("R6 vpn", {12'b0, fault_vpn}, {12'b0, v});
            @(negedge clk);
            check("R10 fault one cycle", {31'b0, fault}, 0);
            check("R6 two reads", reads, 2);
        end
    endtask

    task automatic test_overlap();
        bit ok;
        gnt_wait = 0; rsp_wait = 1;
        mem[32'h0000_0200] = 32'h0000_1001;
        mem[32'h0000_1000] = 32'h0000_F00F;
        mem[32'h0030_0000 + 32'h3FC] = 32'h0040_0001;
        launch(20'h00000, 32'h0000_0200);
        miss_valid = 1'b1; miss_vpn = 20'hFF123; root_base = 32'h0030_0000;
        wait_end(ok);
        if (ok) begin
            check("R9 pte from first walk", done_pte, 32'h0000_F00F);
            @(negedge clk);
            miss_valid = 1'b0;
            check("R9 busy low after pulse", {31'b0, busy}, 0);
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (mem_req || busy) check("R9 miss ignored", 32'd1, 32'd0);
            end
            check("R9 no extra reads", reads, 2);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_good(20'h12345, 32'h0010_0000, 32'h0020_3000, 32'hABCD_E007, 0, 0);
        test_good(20'hFFFFF, 32'h007F_F000, 32'h0040_0000, 32'h1234_5001, 3, 2);
        test_bad_master(20'h00401, 32'h0010_0000);
        test_bad_leaf(20'h12346, 32'h0010_0000, 32'h0020_3000);
        test_overlap();
        test_good(20'h2AB55, 32'h0000_0004, 32'h0066_6000, 32'h7777_7003, 1, 3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule